// File: doc/BRIEF.md
# Edge Capture Channel with Overrun Detection

This block is one input-capture channel tied to its own free-running timer counter. It watches a single external signal and reacts to the edge types selected by a mode field. On each such edge it copies the counter into a capture register and raises a level-type pending flag. That flag drives the interrupt line directly. Software reads the captured count through a read strobe, which marks the value as consumed. It clears flags with explicit strobes and can also sample the live input level.

The channel records whether the held value has been consumed. A capture that lands on a value nobody has read sets a sticky overrun flag. Firmware can compare that flag with the input level to work out which edge it actually got. The input can be passed through a synchronizer to the timer clock before edge detection, or be sampled directly. Parameters choose the counter width, the synchronizer depth, and whether an interrupt acknowledge also clears the pending flag. A further parameter chooses whether an active overrun freezes the capture register.

Top module: `cap_channel`

## Requirements
- R1: After reset the counter, the capture register, the pending flag, the overrun flag, the interrupt and the level output are all zero.
- R2: In rising mode (mode_i = 1) a 0-to-1 input change captures and sets the pending flag; a 1-to-0 change does neither.
- R3: In falling mode (mode_i = 2) a 1-to-0 input change captures and sets the pending flag; a 0-to-1 change does neither.
- R4: In both-edge mode (mode_i = 3) every input change captures and sets the pending flag.
- R5: In off mode (mode_i = 0) input changes leave the capture register and the pending flag unchanged.
- R6: With sync_en_i = 1 the captured value is the counter value SYNC_STAGES cycles after the cycle in which the input changed. With sync_en_i = 0 it is the counter value of that same cycle.
- R7: A capture while the previous value is unread sets ov_o; a capture that follows a rd_cap_i strobe does not.
- R8: ov_o stays set through capture reads and clears only on a clr_ov_i strobe.
- R9: The pending flag is one level bit: several captures merge into it, irq_o equals it, and a clr_ifg_i strobe clears it.
- R10: With AUTO_ACK = 1 an irq_ack_i strobe clears the pending flag; with AUTO_ACK = 0 it has no effect.
- R11: With BLOCK_ON_OV = 1, edges seen while ov_o is set still set the pending flag but leave the capture register unchanged; with BLOCK_ON_OV = 0 the register keeps updating.
- R12: level_o shows the sampled input level that feeds the edge detector.
- R13: When a capture and a clear strobe for the pending or overrun flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | 1 | External signal being captured |
| sync_en_i | input | 1 | 1 routes the signal through the synchronizer |
| mode_i | input | 2 | 0 off, 1 rising, 2 falling, 3 both edges |
| rd_cap_i | input | 1 | Capture register read strobe; marks the value consumed |
| clr_ifg_i | input | 1 | Clears the pending flag |
| clr_ov_i | input | 1 | Clears the overrun flag |
| irq_ack_i | input | 1 | Interrupt acknowledge strobe |
| count_o | output | CNT_W | Live counter value |
| cap_val_o | output | CNT_W | Captured counter value |
| level_o | output | 1 | Sampled input level |
| ifg_o | output | 1 | Capture pending flag |
| ov_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Each edge mode is driven with both a rising and a falling transition. This shows that a mode accepts its own edge and rejects the opposite one, and that off mode ignores both. Single edges are compared with a burst of edges and no reads in between, which separates merging of the pending flag from overrun detection. Burst-read-burst sequences check that a read consumes the value without clearing the overrun flag. Clear strobes are timed to meet a capture in the same cycle. A second instance with acknowledge-clearing off and overrun-freezing on receives the same stimulus, so both variants are compared side by side. Captured counts are checked against the counter value seen when the input was driven, with the synchronizer both on and off.

// File: rtl/cap_pkg.sv
package cap_pkg;
   typedef enum logic [1:0] {
      CAP_OFF  = 2'd0,
      CAP_RISE = 2'd1,
      CAP_FALL = 2'd2,
      CAP_BOTH = 2'd3
   } cap_mode_e;
endpackage

// File: rtl/cap_counter.sv
module cap_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] count_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign count_o = cnt_q;
endmodule

// File: rtl/cap_insync.sv
module cap_insync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cap_edge.sv
module cap_edge
   import cap_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      raw_i,
   input  logic      synced_i,
   input  logic      sync_en_i,
   input  cap_mode_e mode_i,
   output logic      level_o,
   output logic      event_o
);
   logic smp;
   logic prev_q;
   logic rise, fall;

   assign smp = sync_en_i ? synced_i : raw_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= smp;
   end

   assign rise = smp & ~prev_q;
   assign fall = ~smp & prev_q;

   always_comb begin
      unique case (mode_i)
         CAP_RISE: event_o = rise;
         CAP_FALL: event_o = fall;
         CAP_BOTH: event_o = rise | fall;
         default:  event_o = 1'b0;
      endcase
   end

   assign level_o = smp;
endmodule

// File: rtl/cap_channel.sv
module cap_channel
   import cap_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit AUTO_ACK    = 1'b1,
   parameter bit BLOCK_ON_OV = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_in,
   input  logic             sync_en_i,
   input  logic [1:0]       mode_i,
   input  logic             rd_cap_i,
   input  logic             clr_ifg_i,
   input  logic             clr_ov_i,
   input  logic             irq_ack_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] cap_val_o,
   output logic             level_o,
   output logic             ifg_o,
   output logic             ov_o,
   output logic             irq_o
);
   localparam int CW = CNT_W;

   generate
      if (CNT_W < 2)       begin : g_bad_width $error("CNT_W must be at least 2"); end
      if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   logic [CW-1:0] count;
   logic          synced;
   logic          ev;
   logic          take;
   logic          ack_clr;
   logic [CW-1:0] cap_q;
   logic          unread_q;
   logic          ov_q;
   logic          ifg_q;
   cap_mode_e     mode;

   assign mode = cap_mode_e'(mode_i);

   cap_counter #(.CNT_W(CW)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .count_o (count)
   );

   cap_insync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cap_in),
      .q_o   (synced)
   );

   cap_edge u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_i     (cap_in),
      .synced_i  (synced),
      .sync_en_i (sync_en_i),
      .mode_i    (mode),
      .level_o   (level_o),
      .event_o   (ev)
   );

   generate
      if (BLOCK_ON_OV) begin : g_block
         assign take = ev & ~ov_q;
      end else begin : g_free
         assign take = ev;
      end
      if (AUTO_ACK) begin : g_ack
         assign ack_clr = irq_ack_i;
      end else begin : g_noack
         assign ack_clr = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q    <= '0;
         unread_q <= 1'b0;
         ov_q     <= 1'b0;
         ifg_q    <= 1'b0;
      end else begin
         if (take) cap_q <= count;

         if (take)          unread_q <= 1'b1;
         else if (rd_cap_i) unread_q <= 1'b0;

         if (take && unread_q && !rd_cap_i) ov_q <= 1'b1;
         else if (clr_ov_i)                 ov_q <= 1'b0;

         if (ev)                        ifg_q <= 1'b1;
         else if (clr_ifg_i || ack_clr) ifg_q <= 1'b0;
      end
   end

   assign count_o   = count;
   assign cap_val_o = cap_q;
   assign ov_o      = ov_q;
   assign ifg_o     = ifg_q;
   assign irq_o     = ifg_q;
endmodule

// File: rtl/cap_channel_chk.sv
module cap_channel_chk #(
   parameter int CNT_W       = 16,
   parameter bit AUTO_ACK    = 1'b1,
   parameter bit BLOCK_ON_OV = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode_i,
   input logic             clr_ifg_i,
   input logic             clr_ov_i,
   input logic             irq_ack_i,
   input logic [CNT_W-1:0] cap_val_o,
   input logic             ifg_o,
   input logic             ov_o,
   input logic             irq_o
);
   assert_no_edge_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ifg_o) |-> $past(mode_i) != 2'd0);

   assert_no_overflow_without_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ov_o) |-> ifg_o);

   assert_ov_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_o && !clr_ov_i) |=> ov_o);

   assert_ifg_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ifg_o && !clr_ifg_i && !(AUTO_ACK && irq_ack_i)) |=> ifg_o);

   assert_irq_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == ifg_o);

   assert_capture_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_val_o) |-> ifg_o);

   generate
      if (BLOCK_ON_OV) begin : g_blk
         assert_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
            $past(ov_o) |-> $stable(cap_val_o));
      end
   endgenerate
endmodule

bind cap_channel cap_channel_chk #(
   .CNT_W(CNT_W), .AUTO_ACK(AUTO_ACK), .BLOCK_ON_OV(BLOCK_ON_OV)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .clr_ifg_i(clr_ifg_i),
   .clr_ov_i(clr_ov_i), .irq_ack_i(irq_ack_i), .cap_val_o(cap_val_o),
   .ifg_o(ifg_o), .ov_o(ov_o), .irq_o(irq_o)
);

// File: tb/sim_cap_channel.sv
`timescale 1ns/1ps
module sim_cap_channel;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cap_in = 1'b0, sync_en = 1'b1;
   logic [1:0] mode = 2'd0;
   logic rd_cap = 1'b0, clr_ifg = 1'b0, clr_ov = 1'b0, ack = 1'b0;
   logic [15:0] cnt0, cap0, cnt1, cap1;
   logic lvl0, ifg0, ov0, irq0, lvl1, ifg1, ov1, irq1;
   int checks = 0, failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   cap_channel u0 (
      .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .sync_en_i(sync_en), .mode_i(mode),
      .rd_cap_i(rd_cap), .clr_ifg_i(clr_ifg), .clr_ov_i(clr_ov), .irq_ack_i(ack),
      .count_o(cnt0), .cap_val_o(cap0), .level_o(lvl0), .ifg_o(ifg0), .ov_o(ov0), .irq_o(irq0));

   cap_channel #(.AUTO_ACK(1'b0), .BLOCK_ON_OV(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .sync_en_i(sync_en), .mode_i(mode),
      .rd_cap_i(rd_cap), .clr_ifg_i(clr_ifg), .clr_ov_i(clr_ov), .irq_ack_i(ack),
      .count_o(cnt1), .cap_val_o(cap1), .level_o(lvl1), .ifg_o(ifg1), .ov_o(ov1), .irq_o(irq1));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clean();
      rd_cap = 1; clr_ifg = 1; clr_ov = 1;
      @(negedge clk);
      rd_cap = 0; clr_ifg = 0; clr_ov = 0;
      @(negedge clk);
   endtask

   task automatic strobe_rd();
      rd_cap = 1; @(negedge clk); rd_cap = 0; @(negedge clk);
   endtask

   // drive a new input level and wait until the capture has landed
   task automatic drive(input logic v, output logic [15:0] exp);
      exp = sync_en ? cnt0 + 16'd2 : cnt0;
      cap_in = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 count", cnt0, 0);
      chk("R1 cap", cap0, 0);
      chk("R1 ifg", ifg0, 0);
      chk("R1 ov", ov0, 0);
      chk("R1 irq", irq0, 0);
      chk("R1 level", lvl0, 0);
   endtask

   task automatic t_rise();
      logic [15:0] e, held;
      mode = 2'd1; sync_en = 1; clean();
      drive(1, e);
      chk("R2 rise cap", cap0, e);
      chk("R2 rise ifg", ifg0, 1);
      chk("R12 level high", lvl0, 1);
      held = cap0; clean();
      drive(0, e);
      chk("R2 fall ignored ifg", ifg0, 0);
      chk("R2 fall ignored cap", cap0, held);
      chk("R12 level low", lvl0, 0);
   endtask

   task automatic t_fall();
      logic [15:0] e, held;
      mode = 2'd2; clean();
      held = cap0;
      drive(1, e);
      chk("R3 rise ignored ifg", ifg0, 0);
      chk("R3 rise ignored cap", cap0, held);
      drive(0, e);
      chk("R3 fall cap", cap0, e);
      chk("R3 fall ifg", ifg0, 1);
   endtask

   task automatic t_both();
      logic [15:0] e;
      mode = 2'd3; clean();
      drive(1, e);
      chk("R4 rise cap", cap0, e);
      clean();
      drive(0, e);
      chk("R4 fall cap", cap0, e);
      chk("R4 fall ifg", ifg0, 1);
   endtask

   task automatic t_none();
      logic [15:0] e, held;
      mode = 2'd0; clean();
      held = cap0;
      drive(1, e);
      drive(0, e);
      chk("R5 ifg", ifg0, 0);
      chk("R5 cap", cap0, held);
   endtask

   task automatic t_nosync();
      logic [15:0] e;
      mode = 2'd3; sync_en = 0; clean();
      drive(1, e);
      chk("R6 unsynced cap", cap0, e);
      sync_en = 1; repeat (3) @(negedge clk); clean();
      drive(0, e);
      chk("R6 synced cap", cap0, e);
   endtask

   task automatic t_ov();
      logic [15:0] e;
      mode = 2'd3; clean();
      drive(1, e);
      chk("R7 no ov first", ov0, 0);
      drive(0, e);
      chk("R7 ov on unread overwrite", ov0, 1);
      strobe_rd();
      chk("R8 ov survives read", ov0, 1);
      clr_ov = 1; @(negedge clk); clr_ov = 0; @(negedge clk);
      chk("R8 ov cleared", ov0, 0);
      drive(1, e);
      chk("R7 no ov after read", ov0, 0);
   endtask

   task automatic t_merge();
      logic [15:0] e;
      mode = 2'd3; clean();
      drive(0, e);
      drive(1, e);
      chk("R9 merged ifg", ifg0, 1);
      chk("R9 irq", irq0, 1);
      clr_ifg = 1; @(negedge clk); clr_ifg = 0; @(negedge clk);
      chk("R9 cleared ifg", ifg0, 0);
      chk("R9 irq low", irq0, 0);
   endtask

   task automatic t_ack();
      logic [15:0] e;
      mode = 2'd3; clean();
      drive(0, e);
      ack = 1; @(negedge clk); ack = 0; @(negedge clk);
      chk("R10 ack clears", ifg0, 0);
      chk("R10 ack ignored", ifg1, 1);
   endtask

   task automatic t_block();
      logic [15:0] e1, e2, e3;
      mode = 2'd3; clean();
      drive(1, e1);
      drive(0, e2);
      chk("R11 ov blk", ov1, 1);
      drive(1, e3);
      chk("R11 frozen cap", cap1, e2);
      chk("R11 flag still set", ifg1, 1);
      chk("R11 free cap", cap0, e3);
   endtask

   task automatic t_setwins();
      logic [15:0] e;
      mode = 2'd3; clean();
      drive(0, e);
      cap_in = 1;
      @(negedge clk); @(negedge clk);
      clr_ifg = 1; clr_ov = 1;
      @(negedge clk);
      clr_ifg = 0; clr_ov = 0;
      chk("R13 ifg set wins", ifg0, 1);
      chk("R13 ov set wins", ov0, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_rise();
      t_fall();
      t_both();
      t_none();
      t_nosync();
      t_ov();
      t_merge();
      t_ack();
      t_block();
      t_setwins();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog R1-R13 actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule